// File: doc/BRIEF.md
# Fundamental Phasor Estimator

This block turns a stream of signed 16-bit samples from one measurement channel into the fundamental-frequency phasor of that channel. The sampling rate is set so that one power-frequency cycle holds exactly 32 samples. Over each full window of 32 accepted samples the block forms the single bin-1 DFT term as a real part and an imaginary part. It also gives the squared magnitude of that term. A protection algorithm downstream can use these values for impedance work without computing a full transform.

Each accepted sample is multiplied by a cosine weight and a sine weight, both chosen by the sample's position in the window, and each product is added into its own running sum. The weights come from a 32-entry constant table that is built at elaboration. A window-start control drops a partial window and realigns the sample index to zero. After the 32nd sample the block emits one result strobe with the three values, and the sums clear for the next window. Upstream logic is expected to remove decaying offsets. A steady offset cancels by itself over a full cycle.

Top module: `fundamental_phasor`

## Requirements
- R1: While reset is asserted and after it is released, before any window completes, `res_valid` is 0 and `res_re`, `res_im` and `res_mag2` are 0.
- R2: Every 32nd accepted sample counted from reset, from a window start or from the previous result produces exactly one result. `res_valid` is high for the single cycle after the clock edge that takes that sample, and at no other time.
- R3: `res_re` equals the sum over n = 0..31 of x(n)·C(n), where C(n) = round(32767·cos(2πn/32)). The rounding is half away from zero, and n is the sample's index in the window.
- R4: `res_im` equals the negated sum over n = 0..31 of x(n)·S(n), where S(n) = round(32767·sin(2πn/32)), rounded the same way.
- R5: Cycles with `smp_valid` low do not advance the index and do not change the sums, so idle gaps inside a window leave the result unchanged.
- R6: When `win_start` is high, the partial sums are discarded and the index returns to 0. If `smp_valid` is high in the same cycle, that sample becomes index 0 of the new window. Otherwise the next accepted sample is index 0.
- R7: A window of 32 equal samples yields `res_re` = 0 and `res_im` = 0.
- R8: `res_mag2` equals `res_re`² + `res_im`² as an unsigned value. It saturates to 2^64−1 when the true sum does not fit in 64 bits.
- R9: Between result strobes, `res_re`, `res_im` and `res_mag2` hold the last result.
- R10: The sums clear after each result, so a window that directly follows another, with no idle cycle, gives a result that depends only on its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample on `smp_data` is accepted this cycle |
| smp_data | input | 16 | Signed sample |
| win_start | input | 1 | Discard partial window, index returns to 0 |
| res_valid | output | 1 | One-cycle strobe, new result on the outputs |
| res_re | output | 40 | Signed real part of the bin-1 term (Q.15 scaled) |
| res_im | output | 40 | Signed imaginary part of the bin-1 term (Q.15 scaled) |
| res_mag2 | output | 64 | Unsigned saturated squared magnitude |

## Verification
Each result is due in the cycle right after the rising edge that takes the 32nd accepted sample of its window. The three values must be present together with the strobe, with no further latency. When the driver puts a window's last sample on the bus, it stamps the cycle number on which the result is due. The monitor reads the outputs on falling edges, compares the cycle of each strobe with that stamp, and reports any strobe that has no expected entry. The hold checks and the zero checks are made several idle cycles after the result, so no new strobe can overlap the values being checked.

// File: rtl/fp_pkg.sv
package fp_pkg;

  localparam int FP_N     = 32;
  localparam int FP_SMP_W = 16;
  localparam int FP_TW_W  = 16;
  localparam int FP_ACC_W = 40;
  localparam int FP_MAG_W = 64;

  // Quantise a value in [-1,1] to a signed word of w bits, full scale 2^(w-1)-1,
  // rounding half away from zero.
  function automatic int fp_quant(real v, int w);
    real amp;
    real r;
    amp = (2.0 ** (w - 1)) - 1.0;
    r   = v * amp;
    if (r >= 0.0) return $rtoi(r + 0.5);
    else          return -$rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/fp_twiddle_rom.sv
module fp_twiddle_rom
  import fp_pkg::*;
#(
  parameter int N    = FP_N,
  parameter int TW_W = FP_TW_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [IDX_W-1:0]       idx,
  output logic signed [TW_W-1:0] cos_w,
  output logic signed [TW_W-1:0] sin_w
);

  localparam real TWO_PI = 6.283185307179586;

  logic signed [TW_W-1:0] cos_tab [N];
  logic signed [TW_W-1:0] sin_tab [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    localparam real ANG   = TWO_PI * real'(g) / real'(N);
    localparam int  COS_I = fp_quant($cos(ANG), TW_W);
    localparam int  SIN_I = fp_quant($sin(ANG), TW_W);
    assign cos_tab[g] = TW_W'(COS_I);
    assign sin_tab[g] = TW_W'(SIN_I);
  end

  assign cos_w = cos_tab[idx];
  assign sin_w = sin_tab[idx];

endmodule

// File: rtl/fp_window_ctrl.sv
module fp_window_ctrl
  import fp_pkg::*;
#(
  parameter int N = FP_N,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             win_start,
  output logic [IDX_W-1:0] idx_eff,
  output logic             take,
  output logic             last
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  // A restart in this cycle realigns the index before the sample is used.
  always_comb begin
    idx_eff = win_start ? '0 : idx_q;
    take    = smp_valid;
    last    = smp_valid && (idx_eff == IDX_LAST);
  end

  always_comb begin
    idx_d = idx_q;
    if (take) begin
      if (last) idx_d = '0;
      else      idx_d = idx_eff + 1'b1;
    end else if (win_start) begin
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/fp_mac_lane.sv
module fp_mac_lane
  import fp_pkg::*;
#(
  parameter int SMP_W = FP_SMP_W,
  parameter int TW_W  = FP_TW_W,
  parameter int ACC_W = FP_ACC_W,
  localparam int PROD_W = SMP_W + TW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    restart,
  input  logic                    last,
  input  logic signed [SMP_W-1:0] sample,
  input  logic signed [TW_W-1:0]  weight,
  output logic signed [ACC_W-1:0] sum_o
);

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [ACC_W-1:0]  base;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  always_comb begin
    prod     = sample * weight;
    prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    base     = restart ? '0 : acc_q;
    sum_o    = base + prod_ext;
  end

  always_comb begin
    acc_d = acc_q;
    if (take) begin
      if (last) acc_d = '0;
      else      acc_d = sum_o;
    end else if (restart) begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/fp_mag_sq.sv
module fp_mag_sq
  import fp_pkg::*;
#(
  parameter int ACC_W = FP_ACC_W,
  parameter int MAG_W = FP_MAG_W,
  localparam int SQ_W  = 2 * ACC_W,
  localparam int TOT_W = SQ_W + 1
) (
  input  logic signed [ACC_W-1:0] re,
  input  logic signed [ACC_W-1:0] im,
  output logic [MAG_W-1:0]        mag
);

  logic signed [SQ_W-1:0] re_sq;
  logic signed [SQ_W-1:0] im_sq;
  logic [TOT_W-1:0]       tot;

  always_comb begin
    re_sq = re * re;
    im_sq = im * im;
    tot   = {1'b0, re_sq} + {1'b0, im_sq};
  end

  if (MAG_W >= TOT_W) begin : g_wide
    assign mag = MAG_W'(tot);
  end else begin : g_sat
    logic ovf;
    assign ovf = |tot[TOT_W-1:MAG_W];
    assign mag = ovf ? '1 : tot[MAG_W-1:0];
  end

endmodule

// File: rtl/fundamental_phasor.sv
module fundamental_phasor
  import fp_pkg::*;
#(
  parameter int N     = FP_N,
  parameter int SMP_W = FP_SMP_W,
  parameter int TW_W  = FP_TW_W,
  parameter int ACC_W = FP_ACC_W,
  parameter int MAG_W = FP_MAG_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    win_start,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_re,
  output logic signed [ACC_W-1:0] res_im,
  output logic [MAG_W-1:0]        res_mag2
);

  localparam int IDX_W  = $clog2(N);
  localparam int LANES  = 2;

  logic [IDX_W-1:0]        idx_eff;
  logic                    take;
  logic                    last;
  logic signed [TW_W-1:0]  cos_w;
  logic signed [TW_W-1:0]  sin_w;
  logic signed [TW_W-1:0]  lane_w   [LANES];
  logic signed [ACC_W-1:0] lane_sum [LANES];
  logic signed [ACC_W-1:0] fin_re;
  logic signed [ACC_W-1:0] fin_im;
  logic [MAG_W-1:0]        fin_mag;

  logic                    vld_d;
  logic signed [ACC_W-1:0] re_d;
  logic signed [ACC_W-1:0] im_d;
  logic [MAG_W-1:0]        mag_d;

  fp_window_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .win_start(win_start),
    .idx_eff  (idx_eff),
    .take     (take),
    .last     (last)
  );

  fp_twiddle_rom #(.N(N), .TW_W(TW_W)) u_rom (
    .idx  (idx_eff),
    .cos_w(cos_w),
    .sin_w(sin_w)
  );

  assign lane_w[0] = cos_w;
  assign lane_w[1] = sin_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fp_mac_lane #(.SMP_W(SMP_W), .TW_W(TW_W), .ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .restart(win_start),
      .last   (last),
      .sample (smp_data),
      .weight (lane_w[l]),
      .sum_o  (lane_sum[l])
    );
  end

  // Imaginary part carries the minus sign of the forward transform kernel.
  assign fin_re = lane_sum[0];
  assign fin_im = '0 - lane_sum[1];

  fp_mag_sq #(.ACC_W(ACC_W), .MAG_W(MAG_W)) u_mag (
    .re (fin_re),
    .im (fin_im),
    .mag(fin_mag)
  );

  always_comb begin
    vld_d = last;
    re_d  = res_re;
    im_d  = res_im;
    mag_d = res_mag2;
    if (last) begin
      re_d  = fin_re;
      im_d  = fin_im;
      mag_d = fin_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_re    <= '0;
      res_im    <= '0;
      res_mag2  <= '0;
    end else begin
      res_valid <= vld_d;
      res_re    <= re_d;
      res_im    <= im_d;
      res_mag2  <= mag_d;
    end
  end

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int N     = 32,
  parameter int ACC_W = 40,
  parameter int MAG_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic                    win_start,
  input logic                    res_valid,
  input logic signed [ACC_W-1:0] res_re,
  input logic signed [ACC_W-1:0] res_im,
  input logic [MAG_W-1:0]        res_mag2
);

  localparam int CNT_W = $clog2(N) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_d;

  // Independent count of accepted samples in the current window.
  always_comb begin
    cnt_base = (win_start || (cnt_q == FULL)) ? '0 : cnt_q;
    cnt_d    = cnt_base + CNT_W'(smp_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!res_valid && res_re == '0 && res_im == '0 && res_mag2 == '0);
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r2_due_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL) |-> res_valid);

  a_r2_only_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cnt_q == FULL));

  a_r9_hold_re: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_re) |-> res_valid);

  a_r9_hold_im: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_im) |-> res_valid);

  a_r9_hold_mag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_mag2) |-> res_valid);

  a_r8_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_re == '0 && res_im == '0) |-> (res_mag2 == '0));

endmodule

bind fundamental_phasor fp_checker #(
  .N    (N),
  .ACC_W(ACC_W),
  .MAG_W(MAG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .win_start(win_start),
  .res_valid(res_valid),
  .res_re   (res_re),
  .res_im   (res_im),
  .res_mag2 (res_mag2)
);

// File: tb/fundamental_phasor_tb.sv
module fundamental_phasor_tb;

  localparam int CLK_P = 10;
  localparam int N     = 32;
  localparam int ACC_W = 40;
  localparam int MAG_W = 64;
  localparam real TWO_PI = 6.283185307179586;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    smp_valid;
  logic signed [15:0]      smp_data;
  logic                    win_start;
  logic                    res_valid;
  logic signed [ACC_W-1:0] res_re;
  logic signed [ACC_W-1:0] res_im;
  logic [MAG_W-1:0]        res_mag2;

  fundamental_phasor u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .win_start(win_start), .res_valid(res_valid), .res_re(res_re),
    .res_im(res_im), .res_mag2(res_mag2)
  );

  always #(CLK_P / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint      re;
    longint      im;
    logic [63:0] mag;
    int          due;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     fails  = 0;
  int     tc[N];
  int     ts[N];
  int     wbuf[N];
  longint last_re, last_im;
  logic [63:0] last_mag;

  function automatic int q15(real v);
    real r;
    r = v * 32767.0;
    if (r >= 0.0) return $rtoi(r + 0.5);
    else          return -$rtoi(0.5 - r);
  endfunction

  task automatic chk(bit ok, string rq, string what,
                     logic signed [127:0] act, logic signed [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic fill(real amp, int k, real ph, int dc);
    for (int n = 0; n < N; n++) begin
      int v;
      real r;
      r = amp * $cos(TWO_PI * real'(k * n) / real'(N) + ph);
      v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
      v = v + dc;
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      wbuf[n] = v;
    end
  endtask

  task automatic drive(bit v, bit s, int d);
    @(negedge clk);
    smp_valid = v;
    win_start = s;
    smp_data  = 16'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0);
  endtask

  // Driver: computes the expected phasor, then feeds the window.
  task automatic send_window(bit start, int gap, string tag);
    exp_t e;
    longint sr, si;
    logic signed [127:0] r128, i128, tot;
    sr = 0;
    si = 0;
    for (int n = 0; n < N; n++) begin
      sr += longint'(wbuf[n]) * tc[n];
      si += longint'(wbuf[n]) * ts[n];
    end
    e.re  = sr;
    e.im  = -si;
    r128  = e.re;
    i128  = e.im;
    tot   = r128 * r128 + i128 * i128;
    e.mag = (tot > 128'(64'hFFFF_FFFF_FFFF_FFFF)) ? 64'hFFFF_FFFF_FFFF_FFFF : tot[63:0];
    e.tag = tag;
    last_re  = e.re;
    last_im  = e.im;
    last_mag = e.mag;
    for (int n = 0; n < N; n++) begin
      drive(1'b1, start && (n == 0), wbuf[n]);
      if (n == N - 1) begin
        e.due = cyc + 1;
        sb.push_back(e);
      end else if (gap > 0) begin
        idle(gap);
      end
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected result strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, "R2", {"result cycle ", e.tag}, cyc, e.due);
        chk(longint'(res_re) == e.re, "R3", {"real part ", e.tag}, res_re, e.re);
        chk(longint'(res_im) == e.im, "R4", {"imag part ", e.tag}, res_im, e.im);
        chk(res_mag2 == e.mag, "R8", {"squared magnitude ", e.tag},
            {64'b0, res_mag2}, {64'b0, e.mag});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      tc[n] = q15($cos(TWO_PI * real'(n) / real'(N)));
      ts[n] = q15($sin(TWO_PI * real'(n) / real'(N)));
    end
    rst_n = 1'b0; smp_valid = 1'b0; win_start = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    chk(res_re == '0 && res_im == '0, "R1", "re/im in reset", res_re, 0);
    chk(res_mag2 == '0, "R1", "mag in reset", {64'b0, res_mag2}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(res_valid == 1'b0 && res_re == '0, "R1", "idle after reset", res_re, 0);

    // R3: cosine at the fundamental.
    fill(2000.0, 1, 0.0, 0);
    send_window(1'b1, 0, "R3 cosine");
    idle(3);

    // R4: sine at the fundamental.
    fill(1500.0, 1, -TWO_PI / 4.0, 0);
    send_window(1'b0, 0, "R4 sine");
    idle(6);
    chk(longint'(res_re) == last_re, "R9", "held real", res_re, last_re);
    chk(longint'(res_im) == last_im, "R9", "held imag", res_im, last_im);
    chk(res_mag2 == last_mag, "R9", "held mag", {64'b0, res_mag2}, {64'b0, last_mag});

    // R7: constant input.
    fill(0.0, 1, 0.0, 1234);
    send_window(1'b0, 0, "R7 constant");
    idle(3);
    chk(res_re == '0, "R7", "constant real", res_re, 0);
    chk(res_im == '0, "R7", "constant imag", res_im, 0);

    // R5: idle gaps inside a window.
    fill(3000.0, 1, 1.0, 0);
    send_window(1'b0, 2, "R5 gaps");
    idle(3);

    // R6: restart with a sample in the same cycle.
    fill(20000.0, 3, 0.5, 0);
    for (int n = 0; n < 9; n++) drive(1'b1, n == 0, wbuf[n]);
    fill(2500.0, 1, 0.3, 0);
    send_window(1'b1, 0, "R6 restart with sample");
    idle(3);

    // R6: restart alone, next sample is index 0.
    fill(20000.0, 3, 0.5, 0);
    for (int n = 0; n < 7; n++) drive(1'b1, 1'b0, wbuf[n]);
    drive(1'b0, 1'b1, 0);
    fill(1800.0, 1, 2.0, 0);
    send_window(1'b0, 0, "R6 restart alone");
    idle(3);

    // R10: back-to-back windows, then a zero window.
    fill(1000.0, 1, 0.7, 0);
    send_window(1'b1, 0, "R10 first");
    fill(4000.0, 2, 0.2, 0);
    send_window(1'b0, 0, "R10 second harmonic");
    fill(0.0, 1, 0.0, 0);
    send_window(1'b0, 0, "R10 zero window");
    idle(3);
    chk(res_re == '0 && res_im == '0, "R10", "zero window after data", res_re, 0);

    // R8: full scale saturates the squared magnitude.
    fill(32767.0, 1, TWO_PI / 8.0, 0);
    send_window(1'b0, 0, "R8 full scale");
    idle(3);
    chk(res_mag2 == 64'hFFFF_FFFF_FFFF_FFFF, "R8", "saturated mag",
        {64'b0, res_mag2}, {64'b0, 64'hFFFF_FFFF_FFFF_FFFF});

    idle(4);
    chk(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule